// File: doc/BRIEF.md
# Three-wire control bus slave with write-only settings and status readout

This block sits on a three-wire serial control bus driven by a host microcontroller: a mode line, a bit clock and one bidirectional data line. While the mode line is low, the host shifts in an 8-bit address byte. Six of its bits select this device and the two lowest bits choose one of four transfer types. While the mode line is high, the host either sends 8-bit settings words or clocks out a 48-bit status word that the block drives onto the data line.

For settings writes, each word carries a 4-bit value followed by a 4-bit register index. The value is stored in one of five write-only 4-bit registers. A write to the fade command register also gives a one-cycle command strobe. For a status read, the block captures a supplied 48-bit word when the data phase opens and shifts it out least significant bit first. It gives a read-done pulse after the last bit, so that a peak detector upstream can clear itself.

All three bus inputs are brought into the system clock domain through two-stage synchronizers, and every edge is detected there. The bus clock must therefore run well below the system clock.

Top module: `cwire_slave`

## Requirements
- R1: An address byte is taken from eight rising bus-clock edges while the mode line is low, first bit into byte bit 0. The device is selected only when byte bits 7..2 equal 6'b001000, so the matching bytes are 8'h20 to 8'h23. Any other byte leaves every register unchanged.
- R2: Byte bits {1,0} give the transfer type: 2'b00 settings write, 2'b01 allocation write, 2'b10 internal-settings write, 2'b11 status read. Data words sent under types 2'b01 and 2'b10 change no register.
- R3: A settings word is eight rising-edge bits. The first four are the value, least significant bit first, and the last four are the register index, least significant bit first. As a byte this is {index[3:0], value[3:0]}. Register k appears on `cfg_o[4k+3:4k]`, for k = 0..4.
- R4: Words with register index 5 to 15 change no register.
- R5: A settings write to index 4 makes `fade_stb_o` high for exactly one system clock cycle. Writes to other indices do not.
- R6: In a status read, the data phase opens with `status_i` captured and its bit 0 on `bus_dat_o`. Each falling bus-clock edge that follows a rising edge advances to the next bit, so the host receives bits 0..47 in order on its rising edges.
- R7: `bus_dat_oe` is high only during the data phase of a selected status read. It falls within four system cycles of the mode line going low.
- R8: `rd_done_o` pulses for one cycle after the 48th rising bus-clock edge of a status data phase, and only once per phase.
- R9: Synchronous reset clears all registers to 0, except register 1, which resets to 4'b0010. Reset also clears the selection and the output enable.
- R10: One data phase may carry several settings words. A low pulse on the mode line with no clock edges separates words and keeps the selection. The first rising edge of a new address byte drops the selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode_i | input | 1 | Bus mode line: low = address, high = data |
| bus_clk_i | input | 1 | Bus bit clock from the host |
| bus_dat_i | input | 1 | Data line as seen at the pad input |
| bus_dat_o | output | 1 | Status bit to drive onto the data line |
| bus_dat_oe | output | 1 | Output enable for the data line pad |
| status_i | input | 48 | Status word to transmit on a status read |
| cfg_o | output | 20 | Five 4-bit settings registers, register k at bits 4k+3:4k |
| fade_stb_o | output | 1 | One-cycle strobe on a fade command write |
| rd_done_o | output | 1 | One-cycle pulse after the last status bit |

## Verification
A table drives twelve address-byte and word pairs. These cover a write to each of the five registers, indices above 4, the two ignored write types, two non-matching device bytes, and a final overwrite. Together they separate correct decoding from errors in bit order, in the index field or in the device compare. Directed tests then check the reset values, several words in one data phase with mode-low separators, a full 48-bit status read against a word with a distinct pattern (which exposes shift timing or order faults), the enable release, the single done pulse, and that a settings transfer never turns the output driver on.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic [1:0] {
    XF_SETTINGS = 2'b00,
    XF_ALLOC    = 2'b01,
    XF_INTERNAL = 2'b10,
    XF_STATUS   = 2'b11
  } xfer_t;

  localparam int BYTE_W    = 8;
  localparam int BCNT_W    = $clog2(BYTE_W);
  localparam int TYPE_W    = 2;
  localparam int ID_W      = BYTE_W - TYPE_W;
  localparam logic [ID_W-1:0] DEV_ID = 6'b001000;
endpackage

// File: rtl/cwb_sync.sv
module cwb_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] IDLE   = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= IDLE;
    else     st[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[k] <= IDLE;
      else     st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cwb_frontend.sv
module cwb_frontend
  import cwb_pkg::*;
#(
  parameter int DW = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_mode,
  input  logic          s_clk,
  input  logic          s_dat,
  output logic          rise_p,
  output logic          fall_p,
  output logic          mode_rise,
  output logic          sel_q,
  output xfer_t         type_q,
  output logic          wr_vld,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic              clk_d, mode_d;
  logic              mode_fall;
  logic [BYTE_W-1:0] sh_q, sh_nxt;
  logic [BCNT_W-1:0] bcnt_q;
  logic              byte_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_d  <= 1'b1;
      mode_d <= 1'b1;
    end else begin
      clk_d  <= s_clk;
      mode_d <= s_mode;
    end
  end

  assign rise_p    = s_clk & ~clk_d;
  assign fall_p    = ~s_clk & clk_d;
  assign mode_rise = s_mode & ~mode_d;
  assign mode_fall = ~s_mode & mode_d;
  assign sh_nxt    = {s_dat, sh_q[BYTE_W-1:1]};
  assign byte_end  = (bcnt_q == BCNT_W'(BYTE_W-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      bcnt_q  <= '0;
      sel_q   <= 1'b0;
      type_q  <= XF_SETTINGS;
      wr_vld  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_vld <= 1'b0;
      if (mode_rise || mode_fall) begin
        bcnt_q <= '0;
      end else if (rise_p) begin
        sh_q   <= sh_nxt;
        bcnt_q <= byte_end ? '0 : bcnt_q + 1'b1;
        if (!s_mode) begin
          if (bcnt_q == '0) sel_q <= 1'b0;
          if (byte_end) begin
            sel_q  <= (sh_nxt[BYTE_W-1:TYPE_W] == DEV_ID);
            type_q <= xfer_t'(sh_nxt[TYPE_W-1:0]);
          end
        end else if (byte_end && sel_q && type_q == XF_SETTINGS) begin
          wr_vld  <= 1'b1;
          wr_data <= sh_nxt[DW-1:0];
          wr_addr <= sh_nxt[DW+AW-1:DW];
        end
      end
    end
  end

  AST_WR_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    wr_vld |-> (s_mode || mode_fall)) else $error("write outside data phase"); // R3
  AST_SEL_DROP: assert property (@(posedge clk) disable iff (rst)
    (!s_mode && !mode_fall && rise_p && bcnt_q == '0) |=> !sel_q) else $error("selection kept"); // R10
endmodule

// File: rtl/cwb_regfile.sv
module cwb_regfile #(
  parameter int          DW       = 4,
  parameter int          AW       = 4,
  parameter int          NREG     = 5,
  parameter int          IFM_IDX  = 1,
  parameter logic [DW-1:0] IFM_RST = 4'b0010,
  parameter int          FADE_IDX = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_vld,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [NREG*DW-1:0] regs_o,
  output logic             fade_stb
);
  localparam logic [AW-1:0] FADE_A = AW'(FADE_IDX);

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [DW-1:0] RV = (k == IFM_IDX) ? IFM_RST : '0;
    localparam logic [AW-1:0] KA = AW'(k);
    logic [DW-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst)                          r_q <= RV;
      else if (wr_vld && wr_addr == KA) r_q <= wr_data;
    end
    assign regs_o[k*DW +: DW] = r_q;
  end

  always_ff @(posedge clk) begin
    if (rst) fade_stb <= 1'b0;
    else     fade_stb <= wr_vld && (wr_addr == FADE_A);
  end

  AST_IGNORE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && wr_addr >= AW'(NREG)) |=> $stable(regs_o)) else $error("high index wrote"); // R4
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (rst)
    fade_stb |=> !fade_stb) else $error("strobe too long"); // R5
  AST_RST_DEFAULT: assert property (@(posedge clk)
    rst |=> (regs_o[IFM_IDX*DW +: DW] == IFM_RST && regs_o[0 +: DW] == '0 && !fade_stb))
    else $error("reset value"); // R9
endmodule

// File: rtl/cwb_status_tx.sv
module cwb_status_tx #(
  parameter int STAT_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_mode,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              mode_rise,
  input  logic              rd_sel,
  input  logic [STAT_W-1:0] status_i,
  output logic              dat_o,
  output logic              oe_o,
  output logic              done_o
);
  localparam int CW = $clog2(STAT_W + 1);
  localparam logic [CW-1:0] LAST = CW'(STAT_W - 1);
  localparam logic [CW-1:0] FULL = CW'(STAT_W);

  logic [STAT_W-1:0] shr_q;
  logic [CW-1:0]     cnt_q;
  logic              act;

  assign act   = rd_sel && s_mode;
  assign dat_o = shr_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shr_q  <= '0;
      cnt_q  <= '0;
      oe_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      oe_o   <= act;
      if (mode_rise && rd_sel) begin
        shr_q <= status_i;
        cnt_q <= '0;
      end else if (act) begin
        if (rise_p && cnt_q != FULL) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) done_o <= 1'b1;
        end else if (fall_p && cnt_q != '0 && cnt_q != FULL) begin
          shr_q <= {1'b0, shr_q[STAT_W-1:1]};
        end
      end
    end
  end

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !s_mode |=> !oe_o) else $error("driver not released"); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o) else $error("done too long"); // R8
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    done_o |-> cnt_q == FULL) else $error("done early"); // R8
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (oe_o && act && !fall_p && !mode_rise) |=> $stable(dat_o)) else $error("bit moved"); // R6
endmodule

// File: rtl/cwire_slave.sv
module cwire_slave
  import cwb_pkg::*;
#(
  parameter int DW        = 4,
  parameter int AW        = 4,
  parameter int NREG      = 5,
  parameter int STAT_W    = 48,
  parameter int SYNC_STG  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_mode_i,
  input  logic               bus_clk_i,
  input  logic               bus_dat_i,
  output logic               bus_dat_o,
  output logic               bus_dat_oe,
  input  logic [STAT_W-1:0]  status_i,
  output logic [NREG*DW-1:0] cfg_o,
  output logic               fade_stb_o,
  output logic               rd_done_o
);
  logic [2:0]    s_bus;
  logic          rise_p, fall_p, mode_rise, sel_q, wr_vld;
  xfer_t         type_q;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  cwb_sync #(.W(3), .STAGES(SYNC_STG), .IDLE(3'b111)) u_sync (
    .clk(clk), .rst(rst),
    .d({bus_mode_i, bus_clk_i, bus_dat_i}),
    .q(s_bus)
  );

  cwb_frontend #(.DW(DW), .AW(AW)) u_fe (
    .clk(clk), .rst(rst),
    .s_mode(s_bus[2]), .s_clk(s_bus[1]), .s_dat(s_bus[0]),
    .rise_p(rise_p), .fall_p(fall_p), .mode_rise(mode_rise),
    .sel_q(sel_q), .type_q(type_q),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  cwb_regfile #(.DW(DW), .AW(AW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
    .regs_o(cfg_o), .fade_stb(fade_stb_o)
  );

  cwb_status_tx #(.STAT_W(STAT_W)) u_tx (
    .clk(clk), .rst(rst),
    .s_mode(s_bus[2]), .rise_p(rise_p), .fall_p(fall_p),
    .mode_rise(mode_rise),
    .rd_sel(sel_q && type_q == XF_STATUS),
    .status_i(status_i),
    .dat_o(bus_dat_o), .oe_o(bus_dat_oe), .done_o(rd_done_o)
  );

  AST_OE_STATUS_ONLY: assert property (@(posedge clk) disable iff (rst)
    bus_dat_oe |-> (type_q == XF_STATUS)) else $error("driver on for write"); // R7
endmodule

// File: tb/test_cwire_slave.sv
module test_cwire_slave;
  localparam int CLK_P = 10;
  localparam int HB    = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bmode = 1'b1, bclk = 1'b1, bdat = 1'b1;
  logic        dat_o, dat_oe, stb, done;
  logic [47:0] status = 48'hC3A5_1E0F_9B62;
  logic [19:0] cfg;
  int          n_chk = 0, n_bad = 0, n_stb = 0, n_done = 0;

  always #(CLK_P/2) clk = ~clk;

  cwire_slave i_cwire_slave (
    .clk(clk), .rst(rst), .bus_mode_i(bmode), .bus_clk_i(bclk),
    .bus_dat_i(bdat), .bus_dat_o(dat_o), .bus_dat_oe(dat_oe),
    .status_i(status), .cfg_o(cfg), .fade_stb_o(stb), .rd_done_o(done)
  );

  always @(posedge clk) begin
    if (stb)  n_stb++;
    if (done) n_done++;
  end

  // {address byte, word, expected cfg}
  localparam logic [35:0] VEC [0:11] = '{
    {8'h20, 8'h05, 20'h00025},  // R3 reg0
    {8'h20, 8'h1A, 20'h000A5},  // R3 reg1
    {8'h20, 8'h23, 20'h003A5},  // R3 reg2
    {8'h20, 8'h3F, 20'h0F3A5},  // R3 reg3
    {8'h20, 8'h49, 20'h9F3A5},  // R5 reg4
    {8'h20, 8'h57, 20'h9F3A5},  // R4 index 5
    {8'h20, 8'hF1, 20'h9F3A5},  // R4 index 15
    {8'h21, 8'h0C, 20'h9F3A5},  // R2 alloc
    {8'h22, 8'h1C, 20'h9F3A5},  // R2 internal
    {8'h60, 8'h0C, 20'h9F3A5},  // R1 wrong id
    {8'h24, 8'h06, 20'h9F3A5},  // R1 bit 2 set
    {8'h20, 8'h00, 20'h9F3A0}   // R3 overwrite
  };

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      bclk = 1'b0; bdat = b[i]; wt(HB);
      bclk = 1'b1; wt(HB);
    end
  endtask

  task automatic addr_phase(input logic [7:0] b);
    bmode = 1'b0; wt(HB);
    send_bits(b);
    bmode = 1'b1; wt(HB);
  endtask

  task automatic word_gap;
    bmode = 1'b0; wt(HB);
    bmode = 1'b1; wt(HB);
  endtask

  initial begin
    int oe_seen, st0;
    logic [47:0] got;
    wt(4);
    rst = 1'b0; wt(6);
    chk("R9 reset cfg", 48'(cfg), 48'h00020);
    chk("R9 reset oe", 48'(dat_oe), 48'h0);

    for (int v = 0; v < 12; v++) begin
      st0 = n_stb;
      addr_phase(VEC[v][35:28]);
      send_bits(VEC[v][27:20]);
      wt(2 * HB);
      chk($sformatf("R1/R2/R3/R4 vec %0d cfg", v), 48'(cfg), 48'(VEC[v][19:0]));
      chk($sformatf("R5 vec %0d strobes", v), 48'(n_stb - st0),
          (VEC[v][35:28] == 8'h20 && VEC[v][27:24] == 4'h4) ? 48'h1 : 48'h0);
      chk($sformatf("R7 vec %0d oe", v), 48'(dat_oe), 48'h0);
    end

    // R10: several words in one data phase with mode-low gaps
    addr_phase(8'h20);
    send_bits(8'h06); word_gap;
    send_bits(8'h17); word_gap;
    send_bits(8'h48);
    wt(2 * HB);
    chk("R10 multi-word cfg", 48'(cfg), 48'h8F376);
    // R10: new address byte drops selection (wrong id), then data ignored
    addr_phase(8'h61);
    send_bits(8'h0F);
    wt(2 * HB);
    chk("R10 reselect cfg", 48'(cfg), 48'h8F376);

    // R6 R7 R8: status read
    st0 = n_done;
    oe_seen = 0;
    addr_phase(8'h23);
    got = '0;
    for (int i = 0; i < 48; i++) begin
      bclk = 1'b0; wt(HB);
      got[i] = dat_o;
      if (dat_oe) oe_seen++;
      bclk = 1'b1; wt(HB);
    end
    wt(HB);
    chk("R6 status word", got, status);
    chk("R7 oe during read", 48'(oe_seen), 48'd48);
    chk("R8 one done pulse", 48'(n_done - st0), 48'h1);
    bmode = 1'b0; wt(4);
    chk("R7 oe released", 48'(dat_oe), 48'h0);
    bmode = 1'b1; wt(HB);

    // R8 R7: settings transfer type never drives, no done
    st0 = n_done;
    addr_phase(8'h20);
    bclk = 1'b0; wt(HB);
    chk("R7 no drive on write", 48'(dat_oe), 48'h0);
    bclk = 1'b1; wt(HB);
    send_bits(8'h00);
    chk("R8 no done on write", 48'(n_done - st0), 48'h0);

    // R9: reset after writes
    rst = 1'b1; wt(2); rst = 1'b0; wt(2);
    chk("R9 reset again", 48'(cfg), 48'h00020);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule